// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides which of fifteen message slots, if any, accepts a CAN frame that has just been received. The frame deserializer presents the identifier, its format (11-bit standard or 29-bit extended), the data length and the first two data bytes with a one-cycle strobe. One clock later the block reports whether a slot accepted the frame and which one. Slot numbers run from 1 to 15, and the value 0 means no slot took the frame.

Each slot holds an identifier, a format, a direction, an enable, a data-length limit and two option bits. The first option selects how the identifier is compared. It is either compared bit for bit, or compared only where the shared identifier mask has ones. The second option adds a test on the first two data bytes. Each byte has its own 8-bit mask and its own expected value. Slot 15 can only receive. Frames that it accepts go into a four-entry FIFO with full, empty and sticky overrun flags, so that a burst of frames for that slot is not lost before software reads them.

Software configures the block through a single write port. Address 0 loads the shared masks and expected byte values, and addresses 1 to 15 load one slot each.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every slot is disabled, no frame is accepted, res_valid is 0, the FIFO is empty and fifo_ovr is 0.
- R2: res_valid is high for exactly the one cycle after each cycle in which frm_valid is high, and is low at all other times.
- R3: A slot accepts only frames whose format matches its own (frm_ext equal to the slot's ext bit). Standard frames compare only identifier bits [10:0].
- R4: When a slot's global-mask option is 0, every compared identifier bit must equal the stored identifier.
- R5: When a slot's global-mask option is 1, identifier bits where the global identifier mask (written at address 0) holds 0 are ignored. A mask bit of 1 requires equality.
- R6: When a slot's media option is 1, the frame must carry at least 2 data bytes. Byte 0 must then match expected value 0 and byte 1 must match expected value 1. This comparison applies the byte masks when the global-mask option is 1 and is exact when it is 0.
- R7: A slot 1 to 14 written with the transmit bit set never accepts a frame.
- R8: When several slots accept a frame, the lowest-numbered one is reported.
- R9: Slot 15 always receives, even when its transmit bit is written as 1.
- R10: A slot accepts a frame only if the frame's length is no larger than the slot's length setting. Lengths above 8 count as 8 on both sides.
- R11: A frame whose winning slot is 15 is pushed into a 4-entry FIFO. fifo_id and fifo_ext show the oldest entry, fifo_pop removes it, and fifo_full and fifo_empty reflect the count.
- R12: A push while the FIFO is full, with no pop in the same cycle, drops the entry and sets fifo_ovr. fifo_ovr stays set until fifo_ovr_clr is pulsed.
- R13: When no slot accepts the frame, res_hit is 0 and res_idx is 0. Disabled slots never accept a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0 selects the shared masks, 1 to 15 select a slot |
| cfg_id | input | 29 | Slot identifier, or the global identifier mask at address 0 |
| cfg_ext | input | 1 | Slot format, 1 for extended |
| cfg_tx | input | 1 | Slot direction, 1 for transmit |
| cfg_gmask | input | 1 | Slot uses the global masks |
| cfg_media | input | 1 | Slot applies the data-byte test |
| cfg_en | input | 1 | Slot enable |
| cfg_dlc | input | 4 | Slot data-length setting |
| cfg_mmask0 | input | 8 | Byte 0 mask (address 0) |
| cfg_marb0 | input | 8 | Byte 0 expected value (address 0) |
| cfg_mmask1 | input | 8 | Byte 1 mask (address 0) |
| cfg_marb1 | input | 8 | Byte 1 expected value (address 0) |
| frm_valid | input | 1 | Received frame strobe |
| frm_ext | input | 1 | Frame format, 1 for extended |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Frame data length |
| frm_byte0 | input | 8 | First data byte |
| frm_byte1 | input | 8 | Second data byte |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A slot accepted the frame |
| res_idx | output | 4 | Winning slot, 0 if none |
| fifo_pop | input | 1 | Remove the oldest slot-15 entry |
| fifo_ovr_clr | input | 1 | Clear the overrun flag |
| fifo_id | output | 29 | Identifier of the oldest entry |
| fifo_ext | output | 1 | Format of the oldest entry |
| fifo_full | output | 1 | FIFO holds 4 entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_ovr | output | 1 | Sticky overrun flag |

## Verification
The frames are chosen in pairs that differ in a single respect. Identifiers differ only inside or only outside the masked bits, formats differ while the identifier bits are the same, a data byte is changed only in a masked or an unmasked bit, and lengths sit on either side of a slot's limit. Each pair separates exact comparison from masked comparison, or separates one acceptance condition from another. Frames that several slots would accept, and frames for transmit or disabled slots, show priority and direction. A burst of five frames for slot 15, followed by pops, shows FIFO order, the full and empty flags, and the sticky overrun.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

    localparam int NUM_CTR  = 15;
    localparam int ID_W     = 29;
    localparam int STD_W    = 11;
    localparam int IDX_W    = $clog2(NUM_CTR + 1);
    localparam int DLC_W    = 4;
    localparam int MAX_DLC  = 8;
    localparam int BYTE_W   = 8;
    localparam int MEDIA_MIN_LEN = 2;

    typedef struct packed {
        logic             en;
        logic             ext;
        logic             tx;
        logic             gmask;
        logic             media;
        logic [DLC_W-1:0] dlc;
        logic [ID_W-1:0]  id;
    } ctr_cfg_t;

    typedef struct packed {
        logic [ID_W-1:0]   id_mask;
        logic [BYTE_W-1:0] mmask0;
        logic [BYTE_W-1:0] marb0;
        logic [BYTE_W-1:0] mmask1;
        logic [BYTE_W-1:0] marb1;
    } glb_cfg_t;

    typedef struct packed {
        logic              ext;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } frame_t;

    typedef struct packed {
        logic             ext;
        logic [ID_W-1:0]  id;
    } fifo_ent_t;

    function automatic logic [DLC_W-1:0] clip_len(input logic [DLC_W-1:0] d);
        return (d > DLC_W'(MAX_DLC)) ? DLC_W'(MAX_DLC) : d;
    endfunction

    function automatic logic id_equal(input logic [ID_W-1:0] a,
                                      input logic [ID_W-1:0] b,
                                      input logic [ID_W-1:0] mask,
                                      input logic            ext);
        logic [ID_W-1:0] width_sel;
        width_sel = ext ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
        return (((a ^ b) & mask & width_sel) == '0);
    endfunction

    function automatic logic byte_equal(input logic [BYTE_W-1:0] a,
                                        input logic [BYTE_W-1:0] b,
                                        input logic [BYTE_W-1:0] mask);
        return (((a ^ b) & mask) == '0);
    endfunction

endpackage

// File: rtl/acf_cfg_bank.sv
module acf_cfg_bank
    import can_acf_pkg::*;
#(
    parameter int N_CTR = NUM_CTR
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           addr,
    input  ctr_cfg_t                   wr_ctr,
    input  glb_cfg_t                   wr_glb,
    output ctr_cfg_t [N_CTR-1:0]       ctr_q,
    output glb_cfg_t                   glb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q <= '0;
        end else if (we && addr == '0) begin
            glb_q <= wr_glb;
        end
    end

    generate
        for (genvar c = 0; c < N_CTR; c++) begin : g_ctr
            localparam logic RX_ONLY = (c == N_CTR - 1);
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctr_q[c] <= '0;
                end else if (we && addr == IDX_W'(c + 1)) begin
                    ctr_q[c]     <= wr_ctr;
                    ctr_q[c].dlc <= clip_len(wr_ctr.dlc);
                    if (RX_ONLY) begin
                        ctr_q[c].tx <= 1'b0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/acf_match_core.sv
module acf_match_core
    import can_acf_pkg::*;
#(
    parameter int N_CTR = NUM_CTR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctr_cfg_t [N_CTR-1:0] ctr,
    input  glb_cfg_t             glb,
    input  logic                 frm_valid,
    input  frame_t               frm,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_idx,
    output logic                 fifo_push,
    output fifo_ent_t            fifo_ent
);

    logic [N_CTR-1:0]  hit_vec;
    logic [DLC_W-1:0]  frm_len;
    logic              win_any;
    logic [IDX_W-1:0]  win_idx;

    assign frm_len = clip_len(frm.dlc);

    generate
        for (genvar c = 0; c < N_CTR; c++) begin : g_cmp
            logic [ID_W-1:0]   id_msk;
            logic [BYTE_W-1:0] m0, m1;
            logic              id_ok, fmt_ok, len_ok, media_ok;
            always_comb begin
                id_msk   = ctr[c].gmask ? glb.id_mask : {ID_W{1'b1}};
                m0       = ctr[c].gmask ? glb.mmask0 : {BYTE_W{1'b1}};
                m1       = ctr[c].gmask ? glb.mmask1 : {BYTE_W{1'b1}};
                fmt_ok   = (ctr[c].ext == frm.ext);
                id_ok    = id_equal(frm.id, ctr[c].id, id_msk, frm.ext);
                len_ok   = (frm_len <= ctr[c].dlc);
                media_ok = !ctr[c].media ||
                           ((frm_len >= DLC_W'(MEDIA_MIN_LEN)) &&
                            byte_equal(frm.b0, glb.marb0, m0) &&
                            byte_equal(frm.b1, glb.marb1, m1));
                hit_vec[c] = ctr[c].en && !ctr[c].tx && fmt_ok && id_ok &&
                             len_ok && media_ok;
            end
        end
    endgenerate

    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int c = N_CTR - 1; c >= 0; c--) begin
            if (hit_vec[c]) begin
                win_any = 1'b1;
                win_idx = IDX_W'(c + 1);
            end
        end
    end

    assign fifo_push    = frm_valid && win_any && (win_idx == IDX_W'(N_CTR));
    assign fifo_ent.ext = frm.ext;
    assign fifo_ent.id  = frm.ext ? frm.id : {{(ID_W-STD_W){1'b0}}, frm.id[STD_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= frm_valid;
            if (frm_valid) begin
                res_hit <= win_any;
                res_idx <= win_idx;
            end
        end
    end

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);
    assert_result_only_after_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(frm_valid));
    assert_miss_index_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0));
    assert_hit_index_nonzero_R13: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> (res_idx != '0));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !res_hit));

endmodule

// File: rtl/acf_rx_fifo.sv
module acf_rx_fifo
    import can_acf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  fifo_ent_t push_ent,
    input  logic      pop,
    input  logic      ovr_clr,
    output fifo_ent_t head,
    output logic      full,
    output logic      empty,
    output logic      ovr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    fifo_ent_t        mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_pop, do_push;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_ent;
                wptr      <= ptr_inc(wptr);
            end
            if (do_pop) rptr <= ptr_inc(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !do_push) ovr <= 1'b1;
            else if (ovr_clr)     ovr <= 1'b0;
        end
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    assert_overrun_sets_R12: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ovr);
    assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    assert_reset_empty_R1: assert property (@(posedge clk)
        $past(rst) |-> (empty && !ovr));

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_acf_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [28:0]       cfg_id,
    input  logic              cfg_ext,
    input  logic              cfg_tx,
    input  logic              cfg_gmask,
    input  logic              cfg_media,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_dlc,
    input  logic [7:0]        cfg_mmask0,
    input  logic [7:0]        cfg_marb0,
    input  logic [7:0]        cfg_mmask1,
    input  logic [7:0]        cfg_marb1,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [28:0]       frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [7:0]        frm_byte0,
    input  logic [7:0]        frm_byte1,
    output logic              res_valid,
    output logic              res_hit,
    output logic [3:0]        res_idx,
    input  logic              fifo_pop,
    input  logic              fifo_ovr_clr,
    output logic [28:0]       fifo_id,
    output logic              fifo_ext,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fifo_ovr
);

    ctr_cfg_t [NUM_CTR-1:0] ctr_q;
    glb_cfg_t               glb_q;
    ctr_cfg_t               wr_ctr;
    glb_cfg_t               wr_glb;
    frame_t                 frm;
    logic                   push;
    fifo_ent_t              push_ent, head;

    always_comb begin
        wr_ctr.en    = cfg_en;
        wr_ctr.ext   = cfg_ext;
        wr_ctr.tx    = cfg_tx;
        wr_ctr.gmask = cfg_gmask;
        wr_ctr.media = cfg_media;
        wr_ctr.dlc   = cfg_dlc;
        wr_ctr.id    = cfg_id;
        wr_glb.id_mask = cfg_id;
        wr_glb.mmask0  = cfg_mmask0;
        wr_glb.marb0   = cfg_marb0;
        wr_glb.mmask1  = cfg_mmask1;
        wr_glb.marb1   = cfg_marb1;
        frm.ext = frm_ext;
        frm.id  = frm_id;
        frm.dlc = frm_dlc;
        frm.b0  = frm_byte0;
        frm.b1  = frm_byte1;
    end

    acf_cfg_bank #(.N_CTR(NUM_CTR)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wr_ctr (wr_ctr),
        .wr_glb (wr_glb),
        .ctr_q  (ctr_q),
        .glb_q  (glb_q)
    );

    acf_match_core #(.N_CTR(NUM_CTR)) u_match (
        .clk       (clk),
        .rst       (rst),
        .ctr       (ctr_q),
        .glb       (glb_q),
        .frm_valid (frm_valid),
        .frm       (frm),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_idx   (res_idx),
        .fifo_push (push),
        .fifo_ent  (push_ent)
    );

    acf_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (fifo_pop),
        .ovr_clr  (fifo_ovr_clr),
        .head     (head),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .ovr      (fifo_ovr)
    );

    assign fifo_id  = head.id;
    assign fifo_ext = head.ext;

    assert_push_only_slot15_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit && res_idx != 4'd15) |-> $stable(fifo_empty) || fifo_pop
            || $past(fifo_pop));

endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [28:0] cfg_id;
    logic        cfg_ext, cfg_tx, cfg_gmask, cfg_media, cfg_en;
    logic [3:0]  cfg_dlc;
    logic [7:0]  cfg_mmask0, cfg_marb0, cfg_mmask1, cfg_marb1;
    logic        frm_valid, frm_ext;
    logic [28:0] frm_id;
    logic [3:0]  frm_dlc;
    logic [7:0]  frm_byte0, frm_byte1;
    logic        res_valid, res_hit;
    logic [3:0]  res_idx;
    logic        fifo_pop, fifo_ovr_clr;
    logic [28:0] fifo_id;
    logic        fifo_ext, fifo_full, fifo_empty, fifo_ovr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_accept_filter i_can_accept_filter (.*);

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic        hit;
        logic [3:0]  idx;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 29'h123,     4'd8,  8'h00, 8'h00, 1'b1, 4'd1},  // R4 exact, R8 slot 8 also
        '{1'b0, 29'h124,     4'd8,  8'h00, 8'h00, 1'b0, 4'd0},  // R4
        '{1'b1, 29'h1ABCDE5, 4'd8,  8'h00, 8'h00, 1'b1, 4'd2},  // R5 masked low bits
        '{1'b1, 29'h1ABCDF0, 4'd8,  8'h00, 8'h00, 1'b0, 4'd0},  // R5 unmasked bit
        '{1'b0, 29'h200,     4'd8,  8'h00, 8'h00, 1'b0, 4'd0},  // R7 tx slot
        '{1'b0, 29'h305,     4'd8,  8'hA7, 8'h55, 1'b1, 4'd5},  // R6 masked bytes
        '{1'b0, 29'h300,     4'd8,  8'hB0, 8'h55, 1'b0, 4'd0},  // R6 byte0 mismatch
        '{1'b0, 29'h300,     4'd8,  8'hA0, 8'h54, 1'b0, 4'd0},  // R6 byte1 mismatch
        '{1'b0, 29'h300,     4'd1,  8'hA0, 8'h55, 1'b0, 4'd0},  // R6 too short
        '{1'b0, 29'h400,     4'd8,  8'hA0, 8'h55, 1'b1, 4'd6},  // R6 exact bytes
        '{1'b0, 29'h400,     4'd8,  8'hA7, 8'h55, 1'b0, 4'd0},  // R6 exact bytes miss
        '{1'b0, 29'h500,     4'd2,  8'h00, 8'h00, 1'b1, 4'd7},  // R10 at limit
        '{1'b0, 29'h500,     4'd3,  8'h00, 8'h00, 1'b0, 4'd0},  // R10 over limit
        '{1'b0, 29'h123,     4'd15, 8'h00, 8'h00, 1'b1, 4'd1},  // R10 clip to 8
        '{1'b1, 29'h123,     4'd8,  8'h00, 8'h00, 1'b1, 4'd9},  // R3 extended slot
        '{1'b1, 29'h124,     4'd8,  8'h00, 8'h00, 1'b0, 4'd0},  // R3
        '{1'b0, 29'h1FFFF923, 4'd8, 8'h00, 8'h00, 1'b1, 4'd1},  // R3 upper bits ignored
        '{1'b0, 29'h700,     4'd8,  8'h00, 8'h00, 1'b0, 4'd0}   // R13 disabled slot
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [28:0] id, input logic ext,
                      input logic tx, input logic gm, input logic md, input logic en,
                      input logic [3:0] dlc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_id = id; cfg_ext = ext; cfg_tx = tx;
        cfg_gmask = gm; cfg_media = md; cfg_en = en; cfg_dlc = dlc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic ext, input logic [28:0] id, input logic [3:0] dlc,
                        input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_dlc = dlc;
        frm_byte0 = b0; frm_byte1 = b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_id = '0; cfg_ext = 1'b0;
        cfg_tx = 1'b0; cfg_gmask = 1'b0; cfg_media = 1'b0; cfg_en = 1'b0; cfg_dlc = '0;
        cfg_mmask0 = 8'hF0; cfg_marb0 = 8'hA0; cfg_mmask1 = 8'hFF; cfg_marb1 = 8'h55;
        frm_valid = 1'b0; frm_ext = 1'b0; frm_id = '0; frm_dlc = '0;
        frm_byte0 = '0; frm_byte1 = '0; fifo_pop = 1'b0; fifo_ovr_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 res_valid", res_valid, 0);
        check("R1 fifo_empty", fifo_empty, 1);
        check("R1 fifo_ovr", fifo_ovr, 0);
        send(1'b0, 29'h000, 4'd0, 8'h00, 8'h00);
        check("R1 no slot enabled", {res_valid, res_hit, res_idx}, {1'b1, 1'b0, 4'd0});

        wr(4'd0,  29'h1FFFFFF0, 0, 0, 0, 0, 0, 4'd0);
        wr(4'd1,  29'h123,      0, 0, 0, 0, 1, 4'd8);
        wr(4'd2,  29'h1ABCDE0,  1, 0, 1, 0, 1, 4'd8);
        wr(4'd4,  29'h200,      0, 1, 0, 0, 1, 4'd8);
        wr(4'd5,  29'h300,      0, 0, 1, 1, 1, 4'd8);
        wr(4'd6,  29'h400,      0, 0, 0, 1, 1, 4'd8);
        wr(4'd7,  29'h500,      0, 0, 0, 0, 1, 4'd2);
        wr(4'd8,  29'h123,      0, 0, 0, 0, 1, 4'd8);
        wr(4'd9,  29'h123,      1, 0, 0, 0, 1, 4'd8);
        wr(4'd10, 29'h700,      0, 0, 0, 0, 0, 4'd8);
        wr(4'd15, 29'h7F0,      0, 1, 1, 0, 1, 4'd8);

        for (int v = 0; v < NV; v++) begin
            send(VECS[v].ext, VECS[v].id, VECS[v].dlc, VECS[v].b0, VECS[v].b1);
            check($sformatf("R3-R13 vector %0d (R4 R5 R6 R7 R8 R10 R13)", v),
                  {res_valid, res_hit, res_idx}, {1'b1, VECS[v].hit, VECS[v].idx});
        end

        @(negedge clk);
        check("R2 no strobe without frame", res_valid, 0);

        for (int k = 1; k <= 5; k++) begin
            send(1'b0, 29'h7F0 + 29'(k), 4'd8, 8'h00, 8'h00);
            if (k == 1) begin
                check("R9 slot15 receives", {res_hit, res_idx}, {1'b1, 4'd15});
                check("R11 not empty", fifo_empty, 0);
            end
            if (k == 4) begin
                check("R11 full after 4", fifo_full, 1);
                check("R12 no overrun yet", fifo_ovr, 0);
            end
        end
        check("R12 overrun set", fifo_ovr, 1);
        check("R11 head oldest", {fifo_ext, fifo_id}, {1'b0, 29'h7F1});
        send(1'b0, 29'h123, 4'd8, 8'h00, 8'h00);
        check("R11 other slot no push", fifo_full, 1);
        pop1();
        check("R11 head after pop", fifo_id, 29'h7F2);
        check("R11 not full", fifo_full, 0);
        pop1(); pop1();
        check("R12 dropped entry absent", fifo_id, 29'h7F4);
        pop1();
        check("R11 empty after pops", fifo_empty, 1);
        check("R12 overrun sticky", fifo_ovr, 1);
        @(negedge clk); fifo_ovr_clr = 1'b1;
        @(negedge clk); fifo_ovr_clr = 1'b0;
        check("R12 overrun cleared", fifo_ovr, 0);

        send(1'b1, 29'h7F3, 4'd8, 8'h00, 8'h00);
        check("R3 format mismatch on slot15", {res_hit, fifo_empty}, {1'b0, 1'b1});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule